// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This core is a small single-address processor built around one 16-bit accumulator. Every instruction word is 16 bits wide. The upper byte holds the operation code and the lower byte holds either the address of a data word (direct addressing) or, for the load-immediate operation, the operand itself. The core fetches, decodes and executes instructions from an external 256-word by 16-bit memory. That memory holds both the program and its data and is reached through an address port, a write-data port, a read-data port and a write strobe. The read-data port is expected to return the addressed word in the same cycle.

The datapath has no hardwired state machine. A 32-bit microinstruction is read from an internal control store at the address held in a control address register and latched into a control buffer. Each bit of the control buffer drives one control line of the datapath or one action of the next-address sequencer. The sequencer can do four things:

- step to the next microaddress,
- return to the fetch routine at microaddress 0,
- jump to the routine that belongs to the current operation code,
- skip one extra word when the accumulator is negative.

The halt operation freezes the sequencer and raises a status output, which stays high until reset.

Top module: `mc_acc_cpu`

## Requirements
- R1: `rst` is synchronous and active high. After a clock edge with `rst` high, `halted` is 0, `memWe` is 0 and `memAddr` is 0. The first instruction is then fetched from address 0.
- R2: Each instruction is read from the address held by the program counter, which then advances by one. Bits 15:8 are the operation code and bits 7:0 are the address field. While halted, `memAddr` shows the address of the halt instruction.
- R3: Operation code 0x02 loads the word at the address field into the accumulator.
- R4: Operation code 0x01 writes the accumulator to the word at the address field. The write strobe is high for exactly one cycle per store, and no other word changes.
- R5: Operation code 0x03 adds the addressed word to the accumulator. Operation code 0x04 subtracts the addressed word from the accumulator. Both work modulo 2^16.
- R6: Operation code 0x05 ANDs the addressed word into the accumulator, and 0x06 ORs it in.
- R7: Operation code 0x07 puts the bitwise complement of the addressed word into the accumulator.
- R8: Operation code 0x08 shifts the accumulator right by one and inserts 0 at bit 15. Operation code 0x09 shifts it left by one and inserts 0 at bit 0. Neither uses the address field.
- R9: Operation code 0x0B jumps unconditionally to the address field.
- R10: Operation code 0x0A jumps to the address field when accumulator bit 15 is 0. Otherwise execution continues with the next instruction.
- R11: Operation code 0x0E raises `halted`. `halted` stays high until reset, and after it rises there are no further writes and `memAddr` does not change.
- R12: Any operation code not listed in R3 to R13 changes neither the accumulator nor the memory.
- R13: Operation code 0x10 loads the accumulator with the address field zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 8 | Memory address (memory address register) |
| memWdata | output | 16 | Data to be written (memory buffer register) |
| memRdata | input | 16 | Word read from `memAddr`, valid in the same cycle |
| memWe | output | 1 | Write strobe; the memory stores `memWdata` at `memAddr` on the clock edge |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Each arithmetic and logic operation runs as a short load, operate, store and halt program. It is tried on every pair drawn from eight operand patterns: zero, one, the largest positive value, the most negative value, all ones, two alternating-bit words and one mixed value. These pairs separate carry and borrow wrap, sign-bit handling and operand order. Each operand sign also decides which branch of the conditional jump is taken, and zero shows that the jump treats zero as non-negative. A sweep of immediate values and of unused operation codes shows that upper bits are cleared and that unknown codes leave the accumulator and memory untouched. A summing loop with shift, OR and complement exercises back-to-back loop-back jumps and several stores in one program.

// File: rtl/mc_acc_pkg.sv
`timescale 1ns/1ps
package mc_acc_pkg;

  localparam int CW_W = 32;

  // control word bit positions
  localparam int CB_CAR_INC  = 0;
  localparam int CB_CAR_CLR  = 1;
  localparam int CB_CAR_MAP  = 2;
  localparam int CB_CAR_SKIP = 3;
  localparam int CB_MAR_PC   = 4;
  localparam int CB_MAR_MBR  = 5;
  localparam int CB_MBR_MEM  = 6;
  localparam int CB_MBR_ACC  = 7;
  localparam int CB_PC_INC   = 8;
  localparam int CB_PC_MBR   = 9;
  localparam int CB_IR_LD    = 10;
  localparam int CB_BR_MBR   = 11;
  localparam int CB_BR_IMM   = 12;
  localparam int CB_ALU_PASS = 13;
  localparam int CB_ALU_ADD  = 14;
  localparam int CB_ALU_SUB  = 15;
  localparam int CB_ALU_AND  = 16;
  localparam int CB_ALU_OR   = 17;
  localparam int CB_ALU_NOT  = 18;
  localparam int CB_ALU_SHR  = 19;
  localparam int CB_ALU_SHL  = 20;
  localparam int CB_MEM_WR   = 21;
  localparam int CB_HALT     = 22;
  localparam int CB_LAST     = CB_HALT;

  // operation codes
  localparam int OPC_STORE = 8'h01;
  localparam int OPC_LOAD  = 8'h02;
  localparam int OPC_ADD   = 8'h03;
  localparam int OPC_SUB   = 8'h04;
  localparam int OPC_AND   = 8'h05;
  localparam int OPC_OR    = 8'h06;
  localparam int OPC_NOT   = 8'h07;
  localparam int OPC_SHR   = 8'h08;
  localparam int OPC_SHL   = 8'h09;
  localparam int OPC_JGE   = 8'h0A;
  localparam int OPC_JMP   = 8'h0B;
  localparam int OPC_HALT  = 8'h0E;
  localparam int OPC_LDI   = 8'h10;

  // microroutine entry points
  localparam int UA_FETCH = 0;
  localparam int UA_STORE = 8;
  localparam int UA_MEMOP = 12;  // six four-word routines: load, add, sub, and, or, not
  localparam int UA_SHR   = 36;
  localparam int UA_SHL   = 37;
  localparam int UA_JGE   = 40;
  localparam int UA_JMP   = 44;
  localparam int UA_HALT  = 48;
  localparam int UA_LDI   = 52;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOT, ALU_SHR, ALU_SHL
  } aluOp_t;

  typedef struct packed {
    logic   marFromPc;
    logic   marFromMbr;
    logic   mbrFromMem;
    logic   mbrFromAcc;
    logic   pcInc;
    logic   pcFromMbr;
    logic   irLoad;
    logic   brFromMbr;
    logic   brFromImm;
    logic   memWrite;
    aluOp_t aluOp;
  } dpStrobes_t;

endpackage

// File: rtl/mc_acc_alu.sv
`timescale 1ns/1ps
module mc_acc_alu import mc_acc_pkg::*; #(
  parameter int W = 16
) (
  input  aluOp_t       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    case (op)
      ALU_PASS: y = b;
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_NOT:  y = ~b;
      ALU_SHR:  y = {1'b0, a[W-1:1]};
      ALU_SHL:  y = {a[W-2:0], 1'b0};
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/mc_acc_ctrl.sv
`timescale 1ns/1ps
module mc_acc_ctrl import mc_acc_pkg::*; #(
  parameter int OPC_W = 8,
  parameter int CS_AW = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] ir,
  input  logic             accSign,
  output dpStrobes_t       strobes,
  output logic             halted
);

  logic [CS_AW-1:0] car, nextCar;
  logic [CW_W-1:0]  cbr, romWord;

  // control store contents, computed per address
  function automatic logic [CW_W-1:0] ucodeAt(input logic [CS_AW-1:0] a);
    logic [CW_W-1:0] w;
    int ai, grp;
    w  = '0;
    ai = int'(a);
    if (ai == UA_FETCH) begin
      w[CB_MAR_PC] = 1'b1; w[CB_CAR_INC] = 1'b1;
    end else if (ai == UA_FETCH + 1) begin
      w[CB_MBR_MEM] = 1'b1; w[CB_PC_INC] = 1'b1; w[CB_CAR_INC] = 1'b1;
    end else if (ai == UA_FETCH + 2) begin
      w[CB_IR_LD] = 1'b1; w[CB_CAR_INC] = 1'b1;
    end else if (ai == UA_FETCH + 3) begin
      w[CB_CAR_MAP] = 1'b1;
    end else if (ai == UA_STORE) begin
      w[CB_MAR_MBR] = 1'b1; w[CB_CAR_INC] = 1'b1;
    end else if (ai == UA_STORE + 1) begin
      w[CB_MBR_ACC] = 1'b1; w[CB_CAR_INC] = 1'b1;
    end else if (ai == UA_STORE + 2) begin
      w[CB_MEM_WR] = 1'b1; w[CB_CAR_CLR] = 1'b1;
    end else if (ai >= UA_MEMOP && ai < UA_MEMOP + 24) begin
      grp = (ai - UA_MEMOP) / 4;
      case (ai % 4)
        0: begin w[CB_MAR_MBR] = 1'b1; w[CB_CAR_INC] = 1'b1; end
        1: begin w[CB_MBR_MEM] = 1'b1; w[CB_CAR_INC] = 1'b1; end
        2: begin w[CB_BR_MBR]  = 1'b1; w[CB_CAR_INC] = 1'b1; end
        default: begin w[CB_ALU_PASS + grp] = 1'b1; w[CB_CAR_CLR] = 1'b1; end
      endcase
    end else if (ai == UA_SHR) begin
      w[CB_ALU_SHR] = 1'b1; w[CB_CAR_CLR] = 1'b1;
    end else if (ai == UA_SHL) begin
      w[CB_ALU_SHL] = 1'b1; w[CB_CAR_CLR] = 1'b1;
    end else if (ai == UA_JGE) begin
      w[CB_CAR_SKIP] = 1'b1;
    end else if (ai == UA_JGE + 1 || ai == UA_JMP) begin
      w[CB_PC_MBR] = 1'b1; w[CB_CAR_CLR] = 1'b1;
    end else if (ai == UA_HALT) begin
      w[CB_HALT] = 1'b1;
    end else if (ai == UA_LDI) begin
      w[CB_BR_IMM] = 1'b1; w[CB_CAR_INC] = 1'b1;
    end else if (ai == UA_LDI + 1) begin
      w[CB_ALU_PASS] = 1'b1; w[CB_CAR_CLR] = 1'b1;
    end else begin
      w[CB_CAR_CLR] = 1'b1;
    end
    return w;
  endfunction

  // operation code to routine entry; unknown codes go straight back to fetch
  function automatic logic [CS_AW-1:0] mapOpcode(input logic [OPC_W-1:0] opc);
    int target;
    case (int'(opc))
      OPC_STORE: target = UA_STORE;
      OPC_LOAD:  target = UA_MEMOP;
      OPC_ADD:   target = UA_MEMOP + 4;
      OPC_SUB:   target = UA_MEMOP + 8;
      OPC_AND:   target = UA_MEMOP + 12;
      OPC_OR:    target = UA_MEMOP + 16;
      OPC_NOT:   target = UA_MEMOP + 20;
      OPC_SHR:   target = UA_SHR;
      OPC_SHL:   target = UA_SHL;
      OPC_JGE:   target = UA_JGE;
      OPC_JMP:   target = UA_JMP;
      OPC_HALT:  target = UA_HALT;
      OPC_LDI:   target = UA_LDI;
      default:   target = UA_FETCH;
    endcase
    return CS_AW'(target);
  endfunction

  always_comb begin
    nextCar = car;
    if (cbr[CB_CAR_CLR])       nextCar = '0;
    else if (cbr[CB_CAR_MAP])  nextCar = mapOpcode(ir);
    else if (cbr[CB_CAR_SKIP]) nextCar = car + (accSign ? CS_AW'(2) : CS_AW'(1));
    else if (cbr[CB_CAR_INC])  nextCar = car + CS_AW'(1);
  end

  assign romWord = ucodeAt(nextCar);

  always_ff @(posedge clk) begin
    if (rst) begin
      car    <= '0;
      cbr    <= ucodeAt('0);
      halted <= 1'b0;
    end else begin
      car <= nextCar;
      cbr <= romWord;
      if (cbr[CB_HALT]) halted <= 1'b1;
    end
  end

  always_comb begin
    strobes.marFromPc  = cbr[CB_MAR_PC];
    strobes.marFromMbr = cbr[CB_MAR_MBR];
    strobes.mbrFromMem = cbr[CB_MBR_MEM];
    strobes.mbrFromAcc = cbr[CB_MBR_ACC];
    strobes.pcInc      = cbr[CB_PC_INC];
    strobes.pcFromMbr  = cbr[CB_PC_MBR];
    strobes.irLoad     = cbr[CB_IR_LD];
    strobes.brFromMbr  = cbr[CB_BR_MBR];
    strobes.brFromImm  = cbr[CB_BR_IMM];
    strobes.memWrite   = cbr[CB_MEM_WR] & ~halted;
    if (cbr[CB_ALU_PASS])     strobes.aluOp = ALU_PASS;
    else if (cbr[CB_ALU_ADD]) strobes.aluOp = ALU_ADD;
    else if (cbr[CB_ALU_SUB]) strobes.aluOp = ALU_SUB;
    else if (cbr[CB_ALU_AND]) strobes.aluOp = ALU_AND;
    else if (cbr[CB_ALU_OR])  strobes.aluOp = ALU_OR;
    else if (cbr[CB_ALU_NOT]) strobes.aluOp = ALU_NOT;
    else if (cbr[CB_ALU_SHR]) strobes.aluOp = ALU_SHR;
    else if (cbr[CB_ALU_SHL]) strobes.aluOp = ALU_SHL;
    else                      strobes.aluOp = ALU_NONE;
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R11
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(car)); // R11
  AST_ALU_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cbr[CB_ALU_SHL:CB_ALU_PASS])); // R5
  AST_SEQ_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cbr[CB_CAR_SKIP:CB_CAR_INC]) && (cbr[CW_W-1:CB_LAST+1] == '0)); // R2
  AST_CLEAR_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    cbr[CB_CAR_CLR] |=> (car == '0) && strobes.marFromPc); // R2

endmodule

// File: rtl/mc_acc_dpath.sv
`timescale 1ns/1ps
module mc_acc_dpath import mc_acc_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpStrobes_t               strobes,
  input  logic [DATA_W-1:0]        memRdata,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [DATA_W-1:0]        memWdata,
  output logic [DATA_W-ADDR_W-1:0] ir,
  output logic                     accSign
);

  localparam int OPC_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] mar, pc;
  logic [OPC_W-1:0]  irReg;
  logic [DATA_W-1:0] mbr, br, acc, aluY;

  mc_acc_alu #(.W(DATA_W)) u_alu (
    .op (strobes.aluOp),
    .a  (acc),
    .b  (br),
    .y  (aluY)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mar   <= '0;
      pc    <= '0;
      irReg <= '0;
      mbr   <= '0;
      br    <= '0;
      acc   <= '0;
    end else begin
      if (strobes.marFromPc)       mar <= pc;
      else if (strobes.marFromMbr) mar <= mbr[ADDR_W-1:0];

      if (strobes.mbrFromMem)      mbr <= memRdata;
      else if (strobes.mbrFromAcc) mbr <= acc;

      if (strobes.pcFromMbr)       pc <= mbr[ADDR_W-1:0];
      else if (strobes.pcInc)      pc <= pc + ADDR_W'(1);

      if (strobes.irLoad)          irReg <= mbr[DATA_W-1:ADDR_W];

      if (strobes.brFromMbr)       br <= mbr;
      else if (strobes.brFromImm)  br <= DATA_W'(mbr[ADDR_W-1:0]);

      if (strobes.aluOp != ALU_NONE) acc <= aluY;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mbr;
  assign ir       = irReg;
  assign accSign  = acc[DATA_W-1];

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    strobes.memWrite |-> (memWdata == acc)); // R4
  AST_MAR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.marFromPc, strobes.marFromMbr})); // R2
  AST_NO_WRITE_AT_FETCH: assert property (@(posedge clk) disable iff (rst)
    strobes.marFromPc |-> !strobes.memWrite); // R4

endmodule

// File: rtl/mc_acc_cpu.sv
`timescale 1ns/1ps
module mc_acc_cpu import mc_acc_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CS_AW  = 6
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic              halted
);

  localparam int OPC_W = DATA_W - ADDR_W;

  dpStrobes_t       strobes;
  logic [OPC_W-1:0] ir;
  logic             accSign;

  mc_acc_ctrl #(.OPC_W(OPC_W), .CS_AW(CS_AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ir      (ir),
    .accSign (accSign),
    .strobes (strobes),
    .halted  (halted)
  );

  mc_acc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .ir       (ir),
    .accSign  (accSign)
  );

  assign memWe = strobes.memWrite;

endmodule

// File: tb/mc_acc_cpu_tb.sv
`timescale 1ns/1ps
module mc_acc_cpu_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  memAddr;
  logic [15:0] memWdata, memRdata;
  logic        memWe, halted;
  logic [15:0] mem [256];
  int          nChecks = 0;
  int          nFail = 0;
  int          weCount = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mc_acc_cpu u_dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .halted(halted)
  );

  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (!rst && memWe) begin
      mem[memAddr] <= memWdata;
      weCount <= weCount + 1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  function automatic logic [15:0] ins(input int op, input int a);
    return {op[7:0], a[7:0]};
  endfunction

  // reset, release, wait for halt
  task automatic runProg(input string req);
    int cyc;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    weCount = 0;
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) check({req, " halt reached"}, 16'(halted), 16'h1);
  endtask

  function automatic logic [15:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      2:       return b;
      3:       return a + b;
      4:       return a - b;
      5:       return a & b;
      6:       return a | b;
      default: return ~b;
    endcase
  endfunction

  function automatic string opReq(input int op);
    case (op)
      2:       return "R3 load";
      3, 4:    return "R5 add/sub";
      5, 6:    return "R6 and/or";
      default: return "R7 not";
    endcase
  endfunction

  logic [15:0] pats [8];

  initial begin
    pats = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5555, 16'hAAAA, 16'h1234};
    clearMem();
    // R1: reset state
    @(negedge clk);
    check("R1 halted after reset", 16'(halted), 16'h0);
    check("R1 memWe after reset", 16'(memWe), 16'h0);
    check("R1 memAddr after reset", 16'(memAddr), 16'h0);

    // R3 R5 R6 R7 R4 R2: operand sweep for memory-operand operations
    for (int op = 2; op <= 7; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          clearMem();
          mem[0] = ins(2, 8'h80);
          mem[1] = ins(op, 8'h81);
          mem[2] = ins(1, 8'h90);
          mem[3] = ins(8'h0E, 0);
          mem[8'h80] = pats[i];
          mem[8'h81] = pats[j];
          runProg(opReq(op));
          check(opReq(op), mem[8'h90], model(op, pats[i], pats[j]));
          if (i == j) begin
            check("R4 single write strobe", 16'(weCount), 16'h1);
            check("R4 neighbour untouched", mem[8'h91] | mem[8'h8F], 16'h0);
            check("R2 halt instruction address", 16'(memAddr), 16'h3);
          end
        end
      end
    end

    // R8: shifts
    for (int i = 0; i < 8; i++) begin
      for (int sh = 8; sh <= 9; sh++) begin
        clearMem();
        mem[0] = ins(2, 8'h80);
        mem[1] = ins(sh, 8'h55);
        mem[2] = ins(1, 8'h90);
        mem[3] = ins(8'h0E, 0);
        mem[8'h80] = pats[i];
        runProg("R8 shift");
        check("R8 shift", mem[8'h90], (sh == 8) ? (pats[i] >> 1) : (pats[i] << 1));
      end
    end

    // R9 R10: conditional and unconditional jumps
    for (int i = 0; i < 8; i++) begin
      clearMem();
      mem[0] = ins(2, 8'h80);
      mem[1] = ins(8'h0A, 4);
      mem[2] = ins(8'h10, 8'h11);
      mem[3] = ins(8'h0B, 5);
      mem[4] = ins(8'h10, 8'h22);
      mem[5] = ins(1, 8'h90);
      mem[6] = ins(8'h0E, 0);
      mem[8'h80] = pats[i];
      runProg("R10 jump-if-nonnegative");
      check("R10 jump-if-nonnegative", mem[8'h90], pats[i][15] ? 16'h0011 : 16'h0022);
      check("R9 jump lands on store", 16'(memAddr), 16'h6);
    end

    // R13: load immediate clears the upper byte
    for (int v = 0; v < 256; v += 15) begin
      clearMem();
      mem[0] = ins(2, 8'h80);
      mem[1] = ins(8'h10, v);
      mem[2] = ins(1, 8'h90);
      mem[3] = ins(8'h0E, 0);
      mem[8'h80] = 16'hFFFF;
      runProg("R13 load immediate");
      check("R13 load immediate", mem[8'h90], 16'(v));
    end

    // R12 R11: unknown codes are no-ops; halt holds
    begin
      int unk [8] = '{8'h00, 8'h0C, 8'h0D, 8'h0F, 8'h11, 8'h3F, 8'h80, 8'hFF};
      for (int k = 0; k < 8; k++) begin
        clearMem();
        mem[0] = ins(8'h10, 8'h33);
        mem[1] = ins(unk[k], 8'h44);
        mem[2] = ins(1, 8'h90);
        mem[3] = ins(8'h0E, 0);
        runProg("R12 unknown opcode");
        check("R12 accumulator kept", mem[8'h90], 16'h0033);
        check("R12 memory kept", mem[8'h44], 16'h0000);
        for (int c = 0; c < 10; c++) @(negedge clk);
        check("R11 halted held", 16'(halted), 16'h1);
        check("R11 address frozen", 16'(memAddr), 16'h3);
        check("R11 no further write", 16'(weCount), 16'h1);
      end
      rst = 1'b1;
      @(negedge clk);
      check("R11 halted cleared by reset", 16'(halted), 16'h0);
      check("R1 address after reset", 16'(memAddr), 16'h0);
    end

    // R5 R10: summing loop with shift, or, complement
    begin
      logic [15:0] s, expv;
      s = 16'h0;
      for (int n = 1; n <= 10; n++) s = s + 16'(n);
      expv = ~((s >> 1) | 16'h009A);
      clearMem();
      mem[0]  = ins(2, 8'h80);
      mem[1]  = ins(3, 8'h81);
      mem[2]  = ins(1, 8'h80);
      mem[3]  = ins(2, 8'h81);
      mem[4]  = ins(4, 8'h82);
      mem[5]  = ins(1, 8'h81);
      mem[6]  = ins(4, 8'h82);
      mem[7]  = ins(8'h0A, 0);
      mem[8]  = ins(2, 8'h80);
      mem[9]  = ins(8, 0);
      mem[10] = ins(6, 8'h83);
      mem[11] = ins(1, 8'h84);
      mem[12] = ins(7, 8'h84);
      mem[13] = ins(1, 8'h90);
      mem[14] = ins(8'h0E, 0);
      mem[8'h81] = 16'd10;
      mem[8'h82] = 16'd1;
      mem[8'h83] = 16'h009A;
      runProg("R10 loop program");
      check("R5 loop sum", mem[8'h80], s);
      check("R10 loop result", mem[8'h90], expv);
      check("R7 loop result constant", mem[8'h90], 16'hFF64);
      check("R4 loop store count", 16'(weCount), 16'd22);
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule